// File: doc/BRIEF.md
# SCSI DMA Handshake Engine

This block carries bytes between a parallel SCSI data bus and a host DMA request/acknowledge pair. The host first sets the DMA enable mode bit, then writes any value to one of three strobe addresses: one starts a send, one starts a receive in the target role, and one starts a receive in the initiator role. From then on the engine runs the REQ/ACK handshake for each byte and asks the host for data, or gives data to the host, through a DMA request line.

The role is chosen by a mode input. As target the engine drives REQ and waits for the peer's ACK. As initiator it answers the peer's REQ with ACK. A received byte is taken when the peer's strobe falls and is kept in an input-data register. The host marks the last byte by pulsing end-of-process together with its acknowledge. When that byte has completed, the engine stops and sets its end status. The engine raises an interrupt only when the matching mode bit allows it. After a send it also sets a flag saying that the last byte has left on the bus. Bus signals are modelled as active-high internal levels.

Top module: `scsi_dma_engine`

## Requirements
- R1: After reset, req_o, ack_o, drq_o, bus_data_oe_o, end_dma_o, irq_o and last_byte_sent_o are all low.
- R2: A write of any value at address 5 starts a send. A write at address 6 starts a receive only when tgt_role_i is high. A write at address 7 starts a receive only when tgt_role_i is low. Other addresses, a mismatched role, or dma_en_i low leave the engine idle.
- R3: In the target role the engine drives req_o and waits on ack_i, while ack_o stays low. In the initiator role it raises ack_o after req_i rises and drops it after req_i falls, while req_o stays low.
- R4: In a send, the byte on host_wdata_i in the cycle that dack_i is accepted is driven on bus_data_o with bus_data_oe_o high while the engine's own strobe is asserted.
- R5: In a receive, bus_data_i is captured into in_data_o when the peer strobe falls (ack_i as target, req_i as initiator). drq_o then asks the host to take the byte.
- R6: With blk_mode_i low, drq_o is high only while the engine waits for dack_i, and it is low while a bus handshake is in progress.
- R7: With blk_mode_i high, drq_o stays high from the accepted start until the transfer ends.
- R8: A dack_i accepted with eop_i high marks the final byte. Once that byte completes, the engine is idle, drq_o is low and end_dma_o is high.
- R9: At the end of a transfer, irq_o is set only if eop_irq_en_i is high.
- R10: last_byte_sent_o is set when the final byte of a send has been handshaken on the bus, and it stays low after a receive.
- R11: Dropping dma_en_i during a transfer returns the engine to idle on the next edge: req_o, ack_o, drq_o and bus_data_oe_o go low and end_dma_o is not set.
- R12: An accepted start clears end_dma_o, irq_o and last_byte_sent_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_en_i | input | 1 | DMA mode enable bit |
| blk_mode_i | input | 1 | Block mode: DRQ held for the whole transfer |
| tgt_role_i | input | 1 | Target role select |
| eop_irq_en_i | input | 1 | Interrupt on end-of-process enable |
| reg_we_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 3 | Host register address |
| dack_i | input | 1 | Host DMA acknowledge |
| eop_i | input | 1 | End-of-process, valid with dack_i |
| host_wdata_i | input | 8 | Byte from host for a send |
| req_i | input | 1 | REQ driven by the peer |
| ack_i | input | 1 | ACK driven by the peer |
| bus_data_i | input | 8 | SCSI data bus as sampled |
| req_o | output | 1 | REQ driven by this engine |
| ack_o | output | 1 | ACK driven by this engine |
| bus_data_o | output | 8 | Data driven on the bus |
| bus_data_oe_o | output | 1 | Bus data drive enable |
| drq_o | output | 1 | DMA request to host |
| in_data_o | output | 8 | Input-data register |
| end_dma_o | output | 1 | End-of-DMA status |
| irq_o | output | 1 | End-of-process interrupt |
| last_byte_sent_o | output | 1 | Final send byte handshaken |

## Verification
The assertions check on every cycle that both strobes are never driven together, that driven data holds still while it is enabled, that the request line is quiet during a pulse-mode handshake, that an abort releases the bus on the next edge, and that the end, interrupt and last-byte flags stay consistent with each other. Only the bench's scenarios can show the rest: data bytes arrive intact in both directions and both roles, the right strobe address is accepted for each role, block mode holds the request, and an end-of-process on the first byte or on a later byte stops the engine at the correct point.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOST,    // waiting for host dack
    ST_T_OWN,   // target: REQ high, wait peer ACK high
    ST_T_REL,   // target: REQ low, wait peer ACK low
    ST_I_WAIT,  // initiator: wait peer REQ high
    ST_I_OWN    // initiator: ACK high, wait peer REQ low
  } hs_state_e;
endpackage

// File: rtl/scsi_dma_start_dec.sv
module scsi_dma_start_dec #(
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned SEND_ADDR = 5,
  parameter int unsigned TRX_ADDR  = 6,
  parameter int unsigned IRX_ADDR  = 7
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dma_en_i,
  input  logic              tgt_role_i,
  input  logic              idle_i,
  output logic              start_o,
  output logic              start_send_o
);
  logic hit_send, hit_trx, hit_irx;

  assign hit_send = addr_i == ADDR_W'(SEND_ADDR);
  assign hit_trx  = (addr_i == ADDR_W'(TRX_ADDR)) && tgt_role_i;
  assign hit_irx  = (addr_i == ADDR_W'(IRX_ADDR)) && !tgt_role_i;

  assign start_o      = we_i && dma_en_i && idle_i && (hit_send || hit_trx || hit_irx);
  assign start_send_o = hit_send;
endmodule

// File: rtl/scsi_dma_hs.sv
module scsi_dma_hs
  import scsi_dma_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dma_en_i,
  input  logic              blk_mode_i,
  input  logic              tgt_role_i,
  input  logic              start_i,
  input  logic              start_send_i,
  input  logic              dack_i,
  input  logic              eop_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              req_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              req_o,
  output logic              ack_o,
  output logic              drq_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe_o,
  output logic [DATA_W-1:0] in_data_o,
  output logic              idle_o,
  output logic              done_o,
  output logic              done_send_o
);
  hs_state_e        st_q, st_d;
  logic             role_tgt_q, blk_q, send_q, last_q;
  logic [DATA_W-1:0] out_q, in_q;
  logic             peer, own, take_host, bus_done, latch_rx;
  hs_state_e        bus_first_idle, bus_first_run;

  assign peer           = role_tgt_q ? ack_i : req_i;
  assign bus_first_idle = tgt_role_i ? ST_T_OWN : ST_I_WAIT;
  assign bus_first_run  = role_tgt_q ? ST_T_OWN : ST_I_WAIT;
  assign take_host      = (st_q == ST_HOST) && dack_i && dma_en_i;

  always_comb begin
    st_d     = st_q;
    done_o   = 1'b0;
    bus_done = 1'b0;
    unique case (st_q)
      ST_IDLE:   if (start_i) st_d = start_send_i ? ST_HOST : bus_first_idle;
      ST_HOST: begin
        if (dack_i) begin
          if (send_q) st_d = bus_first_run;
          else if (eop_i) begin
            st_d   = ST_IDLE;
            done_o = 1'b1;
          end else st_d = bus_first_run;
        end
      end
      ST_T_OWN:  if (peer) st_d = ST_T_REL;
      ST_T_REL:  if (!peer) bus_done = 1'b1;
      ST_I_WAIT: if (peer) st_d = ST_I_OWN;
      ST_I_OWN:  if (!peer) bus_done = 1'b1;
      default:   st_d = ST_IDLE;
    endcase
    if (bus_done) begin
      if (send_q && last_q) begin
        st_d   = ST_IDLE;
        done_o = 1'b1;
      end else st_d = ST_HOST;
    end
    if (st_q != ST_IDLE && !dma_en_i) begin
      st_d   = ST_IDLE;
      done_o = 1'b0;
    end
  end

  assign latch_rx    = bus_done && !send_q && dma_en_i;
  assign done_send_o = done_o && send_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      role_tgt_q <= 1'b0;
      blk_q      <= 1'b0;
      send_q     <= 1'b0;
      last_q     <= 1'b0;
      out_q      <= '0;
      in_q       <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start_i) begin
        role_tgt_q <= tgt_role_i;
        blk_q      <= blk_mode_i;
        send_q     <= start_send_i;
        last_q     <= 1'b0;
      end
      if (take_host) begin
        last_q <= eop_i;
        if (send_q) out_q <= host_wdata_i;
      end
      if (latch_rx) in_q <= bus_data_i;
    end
  end

  assign own           = (st_q == ST_T_OWN) || (st_q == ST_I_OWN);
  assign req_o         = own && role_tgt_q;
  assign ack_o         = own && !role_tgt_q;
  assign drq_o         = blk_q ? (st_q != ST_IDLE) : (st_q == ST_HOST);
  assign bus_data_oe_o = send_q && (st_q != ST_IDLE) && (st_q != ST_HOST);
  assign bus_data_o    = out_q;
  assign in_data_o     = in_q;
  assign idle_o        = st_q == ST_IDLE;

  p_one_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_o && ack_o));
  p_drq_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blk_q && (req_o || ack_o)) |-> !drq_o);
  p_data_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_data_oe_o && $past(bus_data_oe_o)) |-> $stable(bus_data_o));
  p_abort_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_o && !dma_en_i) |=> (!drq_o && !req_o && !ack_o && !bus_data_oe_o));
endmodule

// File: rtl/scsi_dma_flags.sv
module scsi_dma_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic done_i,
  input  logic done_send_i,
  input  logic irq_en_i,
  output logic end_dma_o,
  output logic irq_o,
  output logic last_byte_sent_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      end_dma_o        <= 1'b0;
      irq_o            <= 1'b0;
      last_byte_sent_o <= 1'b0;
    end else if (start_i) begin
      end_dma_o        <= 1'b0;
      irq_o            <= 1'b0;
      last_byte_sent_o <= 1'b0;
    end else if (done_i) begin
      end_dma_o        <= 1'b1;
      irq_o            <= irq_en_i;
      last_byte_sent_o <= done_send_i;
    end
  end

  p_irq_needs_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> end_dma_o);
  p_lbs_needs_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_byte_sent_o |-> end_dma_o);
  p_start_clears_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!end_dma_o && !irq_o && !last_byte_sent_o));
endmodule

// File: rtl/scsi_dma_engine.sv
module scsi_dma_engine #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned SEND_ADDR = 5,
  parameter int unsigned TRX_ADDR  = 6,
  parameter int unsigned IRX_ADDR  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dma_en_i,
  input  logic              blk_mode_i,
  input  logic              tgt_role_i,
  input  logic              eop_irq_en_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              dack_i,
  input  logic              eop_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              req_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              req_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe_o,
  output logic              drq_o,
  output logic [DATA_W-1:0] in_data_o,
  output logic              end_dma_o,
  output logic              irq_o,
  output logic              last_byte_sent_o
);
  logic idle, start, start_send, done, done_send;

  scsi_dma_start_dec #(
    .ADDR_W(ADDR_W), .SEND_ADDR(SEND_ADDR), .TRX_ADDR(TRX_ADDR), .IRX_ADDR(IRX_ADDR)
  ) u_dec (
    .we_i(reg_we_i), .addr_i(reg_addr_i), .dma_en_i(dma_en_i), .tgt_role_i(tgt_role_i),
    .idle_i(idle), .start_o(start), .start_send_o(start_send)
  );

  scsi_dma_hs #(.DATA_W(DATA_W)) u_hs (
    .clk_i(clk_i), .rst_ni(rst_ni), .dma_en_i(dma_en_i), .blk_mode_i(blk_mode_i),
    .tgt_role_i(tgt_role_i), .start_i(start), .start_send_i(start_send),
    .dack_i(dack_i), .eop_i(eop_i), .host_wdata_i(host_wdata_i),
    .req_i(req_i), .ack_i(ack_i), .bus_data_i(bus_data_i),
    .req_o(req_o), .ack_o(ack_o), .drq_o(drq_o), .bus_data_o(bus_data_o),
    .bus_data_oe_o(bus_data_oe_o), .in_data_o(in_data_o), .idle_o(idle),
    .done_o(done), .done_send_o(done_send)
  );

  scsi_dma_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .done_i(done),
    .done_send_i(done_send), .irq_en_i(eop_irq_en_i), .end_dma_o(end_dma_o),
    .irq_o(irq_o), .last_byte_sent_o(last_byte_sent_o)
  );

  p_end_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_dma_o |-> (!drq_o && !req_o && !ack_o));
endmodule

// File: tb/scsi_dma_engine_tb_top.sv
module scsi_dma_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dma_en = 0, blk = 0, tgt = 0, irq_en = 0, we = 0, dack = 0, eop = 0;
  logic       req_in = 0, ack_in = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, bdata = '0;
  logic       req_out, ack_out, oe, drq, end_dma, irq, lbs;
  logic [7:0] bout, indata;
  int         n_checks = 0, n_err = 0;
  int         seed_dummy;

  always #10 clk = ~clk;

  scsi_dma_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dma_en_i(dma_en), .blk_mode_i(blk), .tgt_role_i(tgt),
    .eop_irq_en_i(irq_en), .reg_we_i(we), .reg_addr_i(addr), .dack_i(dack), .eop_i(eop),
    .host_wdata_i(wdata), .req_i(req_in), .ack_i(ack_in), .bus_data_i(bdata),
    .req_o(req_out), .ack_o(ack_out), .bus_data_o(bout), .bus_data_oe_o(oe), .drq_o(drq),
    .in_data_o(indata), .end_dma_o(end_dma), .irq_o(irq), .last_byte_sent_o(lbs)
  );

  task automatic tick; @(negedge clk); endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] start_addr(input bit send, input bit role_t);
    return send ? 3'd5 : (role_t ? 3'd6 : 3'd7);
  endfunction

  task automatic strobe(input logic [2:0] a);
    addr = a; we = 1'b1; tick; we = 1'b0;
  endtask

  task automatic host_give(input logic [7:0] b, input bit last);
    int t = 0;
    while (!drq && t < 50) begin tick; t++; end
    check("R6 drq before dack", drq, 1);
    dack = 1'b1; eop = last; wdata = b; tick;
    dack = 1'b0; eop = 1'b0; wdata = 8'($urandom);
  endtask

  task automatic peer_side(input bit send, input bit role_t, input bit blk_m, input logic [7:0] b);
    int t = 0;
    if (role_t) begin
      while (!req_out && t < 50) begin tick; t++; end
      check("R3 target req", req_out, 1);
      check("R3 target ack_o low", ack_out, 0);
      if (send) begin
        check("R4 data", bout, b);
        check("R4 oe", oe, 1);
      end
      check("R6 R7 drq during bus", drq, blk_m);
      if (!send) bdata = b;
      ack_in = 1'b1; tick;
      check("R3 target req release", req_out, 0);
      ack_in = 1'b0; tick;
    end else begin
      if (!send) bdata = b;
      req_in = 1'b1; tick;
      check("R3 init ack", ack_out, 1);
      check("R3 init req_o low", req_out, 0);
      if (send) begin
        check("R4 data", bout, b);
        check("R4 oe", oe, 1);
      end
      check("R6 R7 drq during bus", drq, blk_m);
      req_in = 1'b0; tick;
      check("R3 init ack release", ack_out, 0);
    end
    bdata = 8'($urandom);
  endtask

  task automatic run_xfer(input bit send, input bit role_t, input bit blk_m, input int n, input bit ie);
    logic [7:0] b;
    dma_en = 1'b1; tgt = role_t; blk = blk_m; irq_en = ie;
    strobe(start_addr(send, role_t));
    check("R12 end cleared", end_dma, 0);
    check("R12 lbs cleared", lbs, 0);
    if (blk_m) check("R7 drq at start", drq, 1);
    for (int i = 0; i < n; i++) begin
      b = 8'($urandom);
      if (send) begin
        host_give(b, i == n - 1);
        peer_side(1'b1, role_t, blk_m, b);
      end else begin
        peer_side(1'b0, role_t, blk_m, b);
        check("R5 captured byte", indata, b);
        host_give(8'h00, i == n - 1);
      end
    end
    check("R8 drq low at end", drq, 0);
    check("R8 end_dma", end_dma, 1);
    check("R9 irq", irq, ie);
    check("R10 last byte sent", lbs, send);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'd4711);
    tick; tick;
    check("R1 req", req_out, 0); check("R1 ack", ack_out, 0); check("R1 drq", drq, 0);
    check("R1 oe", oe, 0); check("R1 end", end_dma, 0); check("R1 irq", irq, 0);
    check("R1 lbs", lbs, 0);
    rst_n = 1'b1; tick;

    // directed corner cases
    run_xfer(1, 1, 0, 3, 1);
    run_xfer(1, 0, 0, 1, 0);
    run_xfer(0, 1, 1, 4, 1);
    run_xfer(0, 0, 0, 3, 1);
    run_xfer(1, 0, 1, 2, 0);

    // ignored starts (block mode exposes any start on drq)
    blk = 1; dma_en = 0; tgt = 1; strobe(3'd5); tick;
    check("R2 no start without dma_en", drq, 0);
    dma_en = 1; tgt = 0; strobe(3'd6); tick;
    check("R2 addr 6 ignored as initiator", drq, 0);
    tgt = 1; strobe(3'd7); tick;
    check("R2 addr 7 ignored as target", drq, 0);
    strobe(3'd4); tick;
    check("R2 addr 4 ignored", drq, 0);
    check("R2 end kept", end_dma, 1);

    // abort mid-handshake
    blk = 0; tgt = 1; strobe(3'd5);
    host_give(8'hA5, 1'b0);
    check("R11 req before abort", req_out, 1);
    dma_en = 0; tick;
    check("R11 req released", req_out, 0);
    check("R11 drq released", drq, 0);
    check("R11 oe released", oe, 0);
    check("R11 no end", end_dma, 0);
    tick;

    // random mix
    for (int k = 0; k < 12; k++) begin
      run_xfer(1'($urandom), 1'($urandom), 1'($urandom), 1 + int'($urandom % 5), 1'($urandom));
      tick;
    end

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule